// File: doc/BRIEF.md
# Metering Event Interrupt Controller

This block collects single-cycle event pulses from an energy-metering datapath and turns them into one interrupt request line. Each of five event sources has a sticky status bit. A mask register decides which of those bits may pull the request line. The line is modelled as an open-drain driver: the output `irq_drive_low` is the pull-down enable, so a high value means the request is active.

Software reaches the block through a simple single-cycle register port. Status can be read in two ways. The plain status address returns the bits and leaves them unchanged. The clearing address returns the same bits and clears exactly the bits it returned. An event that lands in the same cycle as a clearing read is kept, so no event is ever lost.

Top module: `meter_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every status bit and every mask bit is 0 and `irq_drive_low` is 0.
- R2: An event pulse on `evt_i[k]` sets status bit k at the next clock edge, whatever the mask holds. The bit order is: 0 energy accumulator rollover, 1 accumulator half full, 2 line zero crossing, 3 voltage sag, 4 new waveform sample.
- R3: `irq_drive_low` is 1 exactly when some status bit is set whose mask bit is also set. It changes in the same cycle as the status and mask registers it follows.
- R4: A read of address 4h returns the status in bits 4:0, with zeros above, and leaves the status unchanged.
- R5: A read of address 5h returns the status as it stood in the request cycle, and clears those returned bits.
- R6: An event that arrives in the same cycle as a read of 5h is set in the status after that read.
- R7: A write to address 3h loads the mask from `req_wdata[4:0]`. A read of 3h returns the mask, with zeros in bits 7:5.
- R8: Writes to 4h or 5h change nothing. A read of any address other than 3h, 4h or 5h returns 0.
- R9: Every read produces exactly one `rsp_valid` pulse, one cycle after the request. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 5 | Event pulses, one bit per source |
| req_valid | input | 1 | Register access request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 8 | Read data |
| irq_drive_low | output | 1 | Pull-down enable of the open-drain interrupt line |

## Verification
The assertions assume that `req_valid` is a single-cycle strobe sampled at each edge. They also assume that events are level bits, read once per cycle, with no handshake. The stimulus issues at most one access per cycle and changes inputs only at falling edges. It overlaps events with plain reads, clearing reads and ignored writes, so that the same-cycle merge rules are exercised.

// File: rtl/mic_pkg.sv
package mic_pkg;
  localparam int unsigned EVT_COUNT = 5;
  localparam int unsigned ADR_MASK     = 3;
  localparam int unsigned ADR_STAT     = 4;
  localparam int unsigned ADR_STAT_CLR = 5;

  typedef enum int unsigned {
    EV_ROLLOVER = 0,
    EV_HALF     = 1,
    EV_ZERO_X   = 2,
    EV_SAG      = 3,
    EV_SAMPLE   = 4
  } evt_idx_e;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_PLAIN = 2'd1,
    ACC_CLEAR = 2'd2,
    ACC_MASK  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/mic_status_bank.sv
module mic_status_bank #(
  parameter int unsigned NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               clr_i,
  output logic [NUM_SRC-1:0] stat_q,
  output logic [NUM_SRC-1:0] stat_d
);
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
    // set has priority over the clear of a returned bit
    always_comb stat_d[k] = evt_i[k] | (stat_q[k] & ~clr_i);

    always_ff @(posedge clk) begin
      if (rst) stat_q[k] <= 1'b0;
      else     stat_q[k] <= stat_d[k];
    end
  end
endmodule

// File: rtl/mic_regport.sv
module mic_regport
  import mic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 5,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [NUM_SRC-1:0] stat_q,
  output logic               clr_o,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] mask_d,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data
);
  acc_kind_e   kind;
  logic        is_rd, is_wr;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    is_rd = req_valid & ~req_write;
    is_wr = req_valid & req_write;
    if (req_addr == ADDR_W'(ADR_MASK))          kind = ACC_MASK;
    else if (req_addr == ADDR_W'(ADR_STAT))     kind = ACC_PLAIN;
    else if (req_addr == ADDR_W'(ADR_STAT_CLR)) kind = ACC_CLEAR;
    else                                        kind = ACC_NONE;
  end

  always_comb begin
    clr_o  = is_rd && (kind == ACC_CLEAR);
    mask_d = (is_wr && kind == ACC_MASK) ? req_wdata[NUM_SRC-1:0] : mask_q;
    case (kind)
      ACC_MASK:            rdata_d = DATA_W'(mask_q);
      ACC_PLAIN, ACC_CLEAR: rdata_d = DATA_W'(stat_q);
      default:             rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      mask_q    <= mask_d;
      rsp_valid <= is_rd;
      if (is_rd) rsp_data <= rdata_d;
    end
  end
endmodule

// File: rtl/mic_irq_gen.sv
module mic_irq_gen #(
  parameter int unsigned NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] stat_d,
  input  logic [NUM_SRC-1:0] mask_d,
  output logic               irq_o
);
  // built from next-state values so the flop lines up with status and mask
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(stat_d & mask_d);
  end
endmodule

// File: rtl/meter_irq_ctrl.sv
module meter_irq_ctrl #(
  parameter int unsigned NUM_SRC = 5,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               irq_drive_low
);
  logic [NUM_SRC-1:0] stat_q, stat_d, mask_q, mask_d;
  logic               clr;

  mic_status_bank #(.NUM_SRC(NUM_SRC)) u_stat (
    .clk(clk), .rst(rst), .evt_i(evt_i), .clr_i(clr),
    .stat_q(stat_q), .stat_d(stat_d)
  );

  mic_regport #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .stat_q(stat_q),
    .clr_o(clr), .mask_q(mask_q), .mask_d(mask_d),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  mic_irq_gen #(.NUM_SRC(NUM_SRC)) u_irq (
    .clk(clk), .rst(rst), .stat_d(stat_d), .mask_d(mask_d), .irq_o(irq_drive_low)
  );
endmodule

// File: rtl/meter_irq_ctrl_chk.sv
module meter_irq_ctrl_chk #(
  parameter int unsigned NUM_SRC = 5,
  parameter int unsigned ADDR_W  = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               req_valid,
  input logic               req_write,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [NUM_SRC-1:0] stat_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               rsp_valid,
  input logic               irq_drive_low
);
  logic rd_plain, rd_clr;
  assign rd_plain = req_valid && !req_write && req_addr == ADDR_W'(4);
  assign rd_clr   = req_valid && !req_write && req_addr == ADDR_W'(5);

  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(rst) |-> (stat_q == '0 && mask_q == '0 && !irq_drive_low)); // R1
  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R2
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_drive_low == |(stat_q & mask_q)); // R3
  AST_PLAIN_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (rd_plain && evt_i == '0) |=> stat_q == $past(stat_q)); // R4
  AST_CLEAR_KEEPS_NEW: assert property (@(posedge clk) disable iff (rst)
    rd_clr |=> stat_q == $past(evt_i)); // R6
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid); // R9
  AST_NO_RSP_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!req_valid || req_write) |=> !rsp_valid); // R9
endmodule

bind meter_irq_ctrl meter_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .req_valid(req_valid),
  .req_write(req_write), .req_addr(req_addr), .stat_q(stat_q),
  .mask_q(mask_q), .rsp_valid(rsp_valid), .irq_drive_low(irq_drive_low)
);

// File: tb/meter_irq_ctrl_bench.sv
module meter_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] evt_i = '0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic [7:0] rsp_data;
  logic       irq_drive_low;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [4:0] m_stat = '0, m_mask = '0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  meter_irq_ctrl u_meter_irq_ctrl (
    .clk(clk), .rst(rst), .evt_i(evt_i), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq_drive_low(irq_drive_low)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a response appears
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) chk("R9 unexpected response", 8'd1, 8'd0);
      else chk(tag_q.pop_front(), rsp_data, exp_q.pop_front());
    end
  end

  // driver: one cycle of stimulus; called at a falling edge
  task automatic cyc(input logic v, input logic w, input logic [3:0] a,
                     input logic [7:0] d, input logic [4:0] e, input string tag);
    logic rd;
    rd = v && !w;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; evt_i = e;
    if (rd) begin
      if (a == 4'h3) exp_q.push_back({3'b0, m_mask});
      else if (a == 4'h4 || a == 4'h5) exp_q.push_back({3'b0, m_stat});
      else exp_q.push_back(8'h00);
      tag_q.push_back(tag);
    end
    if (v && w && a == 4'h3) m_mask = d[4:0];
    if (rd && a == 4'h5) m_stat = 5'b0;
    m_stat = m_stat | e;
    @(posedge clk);
    #1;
    chk({"R9 rsp_valid after ", tag}, {7'b0, rsp_valid}, {7'b0, rd});
    chk({"R3 irq after ", tag}, {7'b0, irq_drive_low}, {7'b0, |(m_stat & m_mask)});
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    cyc(1'b1, 1'b0, a, 8'h00, 5'b0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 irq after reset", {7'b0, irq_drive_low}, 8'h00);
    rd(4'h4, "R1 status after reset");
    rd(4'h3, "R1 mask after reset");
    // R2: event recorded while masked, no request
    cyc(1'b0, 1'b0, 4'h0, 8'h00, 5'b00100, "R2 zero crossing event");
    rd(4'h4, "R2 masked event recorded");
    rd(4'h4, "R4 plain read keeps status");
    // R7 / R3: enable the source
    cyc(1'b1, 1'b1, 4'h3, 8'h04, 5'b0, "R7 mask write");
    rd(4'h3, "R7 mask readback");
    // R5: clearing read
    rd(4'h5, "R5 clearing read returns");
    rd(4'h4, "R5 status cleared");
    // R6: events, then clearing read with a same-cycle event
    cyc(1'b0, 1'b0, 4'h0, 8'h00, 5'b01001, "R2 sag and rollover");
    cyc(1'b1, 1'b0, 4'h5, 8'h00, 5'b10000, "R6 clear with new sample");
    rd(4'h4, "R6 new sample survives");
    // R4: plain read with an event in the same cycle
    cyc(1'b1, 1'b0, 4'h4, 8'h00, 5'b00010, "R4 read with half-full event");
    rd(4'h4, "R4 status after merged event");
    // R8: ignored writes, unmapped reads
    cyc(1'b1, 1'b1, 4'h4, 8'h00, 5'b0, "R8 write to status");
    cyc(1'b1, 1'b1, 4'h5, 8'hFF, 5'b0, "R8 write to clear address");
    rd(4'h4, "R8 status unchanged");
    rd(4'h7, "R8 unmapped read");
    rd(4'h0, "R8 unmapped read low");
    // R7 upper bits, R3 with full mask then partial mask
    cyc(1'b1, 1'b1, 4'h3, 8'hFF, 5'b0, "R7 full mask write");
    rd(4'h3, "R7 mask upper bits zero");
    cyc(1'b1, 1'b1, 4'h3, 8'h01, 5'b0, "R3 mask only rollover");
    cyc(1'b0, 1'b0, 4'h0, 8'h00, 5'b00001, "R3 rollover raises request");
    rd(4'h5, "R5 clear all");
    rd(4'h4, "R5 empty after clear");
    cyc(1'b0, 1'b0, 4'h0, 8'h00, 5'b0, "idle");
    chk("R9 scoreboard drained", 8'(exp_q.size()), 8'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule